// File: doc/BRIEF.md
# Memory-Mapped 32-Pin GPIO Port

This block is a general-purpose I/O port of 32 pins behind a word-wide register bus. Software sets pin levels through an output register and sets pin directions through a direction register. Both registers can be written whole, or through set-only and clear-only aliases. Each pin also has its own configuration word. That word selects whether the input buffer is connected, which pull resistor applies, and a drive mode that can switch the driver off depending on the level being driven.

Direction is held once in hardware but appears in two places: the direction register and bit 0 of every pin's configuration word. Writing either one changes the other. The pin side takes an external drive level with a per-pin "driven" mask. It returns an output enable and a level for each pad. It keeps a registered input sample for each pin, which software reads through the bus. It also keeps a sticky per-pin flag that marks a pin driven by the port and by the outside world at opposite levels.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration word reads 0x00000002, the output, input and direction registers read zero, all pad enables are low, and the short and bus-error flags are clear.
- R2: A write at offset 0x000 replaces the output register, a write at 0x004 ORs the data into it, and a write at 0x008 clears every bit that is set in the data. A read at any of these three offsets returns the output register one cycle after the request.
- R3: Writes at 0x010, 0x014 and 0x018 update the direction register in the same replace/set/clear way, and reads at those offsets return it. Afterwards, bit 0 of each pin's configuration word reads as that pin's direction bit.
- R4: The configuration word of pin n sits at offset 0x080 + 4n. A write there stores the whole word and copies data bit 0 into direction bit n.
- R5: Configuration fields: bit 0 is direction (1 = output) and bits 10:8 are the drive code. Codes 0–3 always allow driving, codes 4–5 allow it only while the output bit is 1, and codes 6–7 allow it only while the output bit is 0. The pad is enabled with the output bit as its level only when the drive code allows it and the direction is output.
- R6: When bit 1 is set (input buffer off) and bits 3:2 select a pull, the input bit read at offset 0x00C takes the pull level. Pull code 1 is pull-down (0), code 3 is pull-up (1), and codes 0 and 2 mean no pull. This holds even when the pin is driven externally.
- R7: With the input buffer on and no external drive, the input bit follows the output bit if the driver is enabled. Otherwise, with a pull selected, the pad is enabled at the pull level and the input bit takes that level. With neither, the pad is off and the input bit keeps its last value.
- R8: With the input buffer on and the pin driven externally, the input bit takes the external level and no pull drives the pad.
- R9: A pin whose input buffer is on, whose driver is enabled, and which is driven externally at a different level raises its short flag on the next clock. The flag then stays set until reset.
- R10: A read at an unmapped or misaligned offset returns zero. A write at an unmapped or misaligned offset, or at the read-only input offset 0x00C, changes no register. Either one sets a sticky bus-error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | Sticky flag for unmapped or misaligned accesses |
| ext_drive_en | input | 32 | Per-pin: pin is driven from outside |
| ext_drive_level | input | 32 | Per-pin external drive level |
| pad_oe | output | 32 | Per-pin output driver enable |
| pad_level | output | 32 | Per-pin level to drive |
| short_flags | output | 32 | Per-pin sticky short-circuit flags |

## Verification
The assertions assume at most one bus access per cycle, with bus_valid, bus_write, the address and the data held steady across the sampling edge. They also assume the external mask and level change only between edges. The bench drives every input at the falling edge and raises bus_valid for exactly one cycle per access, so each property sees one clean request at a time. The short-flag property assumes a flag rises only where the previous cycle showed an external drive on an output pin. The bench only ever creates clashes under those conditions, and it also drives an output pin against the outside while its input buffer is off, to confirm that no flag rises then.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned REG_W = 32;

    localparam int unsigned OFS_OUT      = 'h000;
    localparam int unsigned OFS_OUT_SET  = 'h004;
    localparam int unsigned OFS_OUT_CLR  = 'h008;
    localparam int unsigned OFS_IN       = 'h00C;
    localparam int unsigned OFS_DIR      = 'h010;
    localparam int unsigned OFS_DIR_SET  = 'h014;
    localparam int unsigned OFS_DIR_CLR  = 'h018;
    localparam int unsigned OFS_CFG_BASE = 'h080;

    localparam logic [REG_W-1:0] CFG_RESET = 32'h0000_0002;

    typedef enum logic [3:0] {
        K_NONE,
        K_OUT,
        K_OUT_SET,
        K_OUT_CLR,
        K_IN,
        K_DIR,
        K_DIR_SET,
        K_DIR_CLR,
        K_CFG
    } reg_kind_e;

    // Fields of a configuration word that the pin logic consumes
    typedef struct packed {
        logic [2:0] drive;
        logic [1:0] pull;
        logic       in_off;
        logic       dir;
    } pin_ctl_t;

    // Result of one pin's combinational evaluation
    typedef struct packed {
        logic oe;
        logic level;
        logic in_next;
        logic clash;
    } pin_eval_t;

    function automatic logic pull_active(input logic [1:0] code);
        return (code == 2'b01) || (code == 2'b11);
    endfunction

    function automatic logic pull_level(input logic [1:0] code);
        return code[1];
    endfunction

    function automatic logic drive_allows(input logic [2:0] code, input logic lvl);
        logic ok;
        if (!code[2])      ok = 1'b1;
        else if (!code[1]) ok = lvl;
        else               ok = !lvl;
        return ok;
    endfunction

    function automatic pin_eval_t eval_pin(
        input pin_ctl_t ctl,
        input logic     out_bit,
        input logic     ext_en,
        input logic     ext_lvl,
        input logic     in_now
    );
        pin_eval_t r;
        logic drv;
        logic pon;
        logic plv;
        drv = ctl.dir && drive_allows(ctl.drive, out_bit);
        pon = pull_active(ctl.pull);
        plv = pull_level(ctl.pull);
        r.oe      = drv;
        r.level   = out_bit;
        r.in_next = in_now;
        r.clash   = 1'b0;
        if (ctl.in_off) begin
            if (pon)         r.in_next = plv;
            else if (ext_en) r.in_next = ext_lvl;
        end else if (ext_en) begin
            r.in_next = ext_lvl;
            r.clash   = drv && (out_bit != ext_lvl);
        end else if (drv) begin
            r.in_next = out_bit;
        end else if (pon) begin
            r.oe      = 1'b1;
            r.level   = plv;
            r.in_next = plv;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_PINS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  pin
);

    localparam logic [ADDR_W-1:0] A_OUT     = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET);
    localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR);
    localparam logic [ADDR_W-1:0] A_IN      = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_DIR_SET = ADDR_W'(OFS_DIR_SET);
    localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'(OFS_DIR_CLR);
    localparam logic [ADDR_W-1:0] A_CFG_LO  = ADDR_W'(OFS_CFG_BASE);
    localparam logic [ADDR_W-1:0] A_CFG_HI  = ADDR_W'(OFS_CFG_BASE + 4 * NUM_PINS);

    logic [ADDR_W-1:0] cfg_word;
    assign cfg_word = (addr - A_CFG_LO) >> 2;

    always_comb begin
        kind = K_NONE;
        pin  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= A_CFG_LO && addr < A_CFG_HI) begin
                kind = K_CFG;
                pin  = IDX_W'(cfg_word);
            end else begin
                case (addr)
                    A_OUT:     kind = K_OUT;
                    A_OUT_SET: kind = K_OUT_SET;
                    A_OUT_CLR: kind = K_OUT_CLR;
                    A_IN:      kind = K_IN;
                    A_DIR:     kind = K_DIR;
                    A_DIR_SET: kind = K_DIR_SET;
                    A_DIR_CLR: kind = K_DIR_CLR;
                    default:   kind = K_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  reg_kind_e            kind,
    input  logic [IDX_W-1:0]     pin,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [NUM_PINS-1:0]  in_vec,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 bus_err,
    output logic [NUM_PINS-1:0]  out_q,
    output logic [NUM_PINS-1:0]  dir_q,
    output pin_ctl_t             ctl [NUM_PINS]
);

    // Bits 31:1 of each configuration word; bit 0 lives only in dir_q
    logic [REG_W-1:1]    cfg_rest [NUM_PINS];
    logic [NUM_PINS-1:0] wd_pins;
    logic [REG_W-1:0]    rd_word;

    assign wd_pins = bus_wdata[NUM_PINS-1:0];

    always_comb begin
        case (kind)
            K_OUT, K_OUT_SET, K_OUT_CLR: rd_word = REG_W'(out_q);
            K_DIR, K_DIR_SET, K_DIR_CLR: rd_word = REG_W'(dir_q);
            K_IN:                        rd_word = REG_W'(in_vec);
            K_CFG:                       rd_word = {cfg_rest[pin], dir_q[pin]};
            default:                     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            dir_q     <= '0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            for (int i = 0; i < NUM_PINS; i++) begin
                cfg_rest[i] <= CFG_RESET[REG_W-1:1];
            end
        end else if (bus_valid) begin
            if (bus_write) begin
                case (kind)
                    K_OUT:     out_q <= wd_pins;
                    K_OUT_SET: out_q <= out_q | wd_pins;
                    K_OUT_CLR: out_q <= out_q & ~wd_pins;
                    K_DIR:     dir_q <= wd_pins;
                    K_DIR_SET: dir_q <= dir_q | wd_pins;
                    K_DIR_CLR: dir_q <= dir_q & ~wd_pins;
                    K_CFG: begin
                        cfg_rest[pin] <= bus_wdata[REG_W-1:1];
                        dir_q[pin]    <= bus_wdata[0];
                    end
                    default:   bus_err <= 1'b1;
                endcase
            end else begin
                bus_rdata <= rd_word;
                if (kind == K_NONE) begin
                    bus_err <= 1'b1;
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ctl
        assign ctl[p].dir    = dir_q[p];
        assign ctl[p].in_off = cfg_rest[p][1];
        assign ctl[p].pull   = cfg_rest[p][3:2];
        assign ctl[p].drive  = cfg_rest[p][10:8];
    end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_ctl_t ctl,
    input  logic     out_bit,
    input  logic     ext_en,
    input  logic     ext_level,
    output logic     pad_oe,
    output logic     pad_level,
    output logic     in_bit,
    output logic     clash_flag
);

    pin_eval_t ev;

    assign ev        = eval_pin(ctl, out_bit, ext_en, ext_level, in_bit);
    assign pad_oe    = ev.oe;
    assign pad_level = ev.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_bit     <= 1'b0;
            clash_flag <= 1'b0;
        end else begin
            in_bit <= ev.in_next;
            if (ev.clash) begin
                clash_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_err,
    input  logic [NUM_PINS-1:0] ext_drive_en,
    input  logic [NUM_PINS-1:0] ext_drive_level,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_level,
    output logic [NUM_PINS-1:0] short_flags
);

    localparam int unsigned IDX_W = $clog2(NUM_PINS);

    reg_kind_e           kind;
    logic [IDX_W-1:0]    pin;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] in_vec;
    pin_ctl_t            ctl [NUM_PINS];

    gpio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PINS (NUM_PINS)
    ) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .pin  (pin)
    );

    gpio_regbank #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .kind      (kind),
        .pin       (pin),
        .bus_wdata (bus_wdata),
        .in_vec    (in_vec),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .ctl       (ctl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .ctl        (ctl[p]),
            .out_bit    (out_q[p]),
            .ext_en     (ext_drive_en[p]),
            .ext_level  (ext_drive_level[p]),
            .pad_oe     (pad_oe[p]),
            .pad_level  (pad_level[p]),
            .in_bit     (in_vec[p]),
            .clash_flag (short_flags[p])
        );
    end

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                bus_err,
    input logic [NUM_PINS-1:0] ext_drive_en,
    input logic [NUM_PINS-1:0] out_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] short_flags
);

    localparam int unsigned IDX_W = $clog2(NUM_PINS);

    logic                wr;
    logic                in_cfg;
    logic [ADDR_W-1:0]   rel;
    logic [IDX_W-1:0]    cfg_pin;
    logic [NUM_PINS-1:0] wd;

    assign wr      = bus_valid && bus_write;
    assign wd      = bus_wdata[NUM_PINS-1:0];
    assign rel     = bus_addr - ADDR_W'(OFS_CFG_BASE);
    assign cfg_pin = IDX_W'(rel >> 2);
    assign in_cfg  = (bus_addr[1:0] == 2'b00) &&
                     (bus_addr >= ADDR_W'(OFS_CFG_BASE)) &&
                     (bus_addr <  ADDR_W'(OFS_CFG_BASE + 4 * NUM_PINS));

    a_r2_out_replace: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == ADDR_W'(OFS_OUT) |=> out_q == $past(wd));

    a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == ADDR_W'(OFS_OUT_SET) |=> out_q == ($past(out_q) | $past(wd)));

    a_r2_out_clear: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == ADDR_W'(OFS_OUT_CLR) |=> out_q == ($past(out_q) & ~$past(wd)));

    a_r3_dir_set: assert property (@(posedge clk) disable iff (rst)
        wr && bus_addr == ADDR_W'(OFS_DIR_SET) |=> dir_q == ($past(dir_q) | $past(wd)));

    a_r4_cfg_to_dir: assert property (@(posedge clk) disable iff (rst)
        wr && in_cfg |=> dir_q[$past(cfg_pin)] == $past(bus_wdata[0]));

    a_r9_short_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (short_flags & $past(short_flags)) == $past(short_flags));

    a_r9_short_cause: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (short_flags & ~$past(short_flags) & ~$past(ext_drive_en & dir_q)) == '0);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> bus_err);

    a_r10_misaligned_read: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_write && bus_addr[1:0] != 2'b00 |=> bus_rdata == '0 && bus_err);

endmodule

bind gpio_port gpio_port_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .ext_drive_en (ext_drive_en),
    .out_q        (out_q),
    .dir_q        (dir_q),
    .short_flags  (short_flags)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] ext_drive_en = '0;
    logic [31:0] ext_drive_level = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_level;
    logic [31:0] short_flags;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port u_gpio_port (
        .clk             (clk),
        .rst             (rst),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .bus_err         (bus_err),
        .ext_drive_en    (ext_drive_en),
        .ext_drive_level (ext_drive_level),
        .pad_oe          (pad_oe),
        .pad_level       (pad_level),
        .short_flags     (short_flags)
    );

    function automatic logic [11:0] cfg_addr(input int p);
        return 12'(12'h080 + 4 * p);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic in_bit(input int p, output logic [31:0] b);
        logic [31:0] v;
        bus_rd(12'h00C, v);
        b = (v >> p) & 32'h1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(cfg_addr(5), v);  check("R1 cfg5", v, 32'h2);
        bus_rd(cfg_addr(31), v); check("R1 cfg31", v, 32'h2);
        bus_rd(12'h000, v);      check("R1 out", v, 0);
        bus_rd(12'h010, v);      check("R1 dir", v, 0);
        bus_rd(12'h00C, v);      check("R1 in", v, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 short", short_flags, 0);
        check("R1 bus_err", 32'(bus_err), 0);
    endtask

    task automatic t_out_regs();
        logic [31:0] v;
        bus_wr(12'h000, 32'hA5A5_0F0F);
        bus_rd(12'h004, v); check("R2 replace", v, 32'hA5A5_0F0F);
        bus_wr(12'h004, 32'h0000_F000);
        bus_rd(12'h008, v); check("R2 set", v, 32'hA5A5_FF0F);
        bus_wr(12'h008, 32'hA000_000F);
        bus_rd(12'h000, v); check("R2 clear", v, 32'h05A5_FF00);
    endtask

    task automatic t_dir_regs();
        logic [31:0] v;
        bus_wr(12'h010, 32'h0000_00F0);
        bus_rd(cfg_addr(4), v); check("R3 cfg4 mirror", v, 32'h3);
        bus_rd(cfg_addr(0), v); check("R3 cfg0 mirror", v, 32'h2);
        bus_wr(12'h014, 32'h1);
        bus_wr(12'h018, 32'h10);
        bus_rd(12'h018, v);     check("R3 dir set/clear", v, 32'hE1);
        bus_rd(cfg_addr(4), v); check("R3 cfg4 cleared", v, 32'h2);
        bus_wr(12'h010, 32'h0);
    endtask

    task automatic t_cfg_mirror();
        logic [31:0] v;
        bus_wr(cfg_addr(7), 32'h0000_0301);
        bus_rd(12'h010, v);     check("R4 dir from cfg", v, 32'h80);
        bus_rd(cfg_addr(7), v); check("R4 cfg store", v, 32'h301);
        bus_wr(cfg_addr(7), 32'h0000_0300);
        bus_rd(12'h014, v);     check("R4 dir cleared", v, 32'h0);
        bus_wr(cfg_addr(7), 32'h2);
    endtask

    task automatic t_drive_modes();
        bus_wr(12'h000, 32'h0);
        bus_wr(cfg_addr(9), 32'h0000_0401);
        check("R5 code4 out0 off", 32'(pad_oe[9]), 0);
        bus_wr(12'h004, 32'h200);
        check("R5 code4 out1 on", 32'(pad_oe[9]), 1);
        check("R5 code4 level", 32'(pad_level[9]), 1);
        bus_wr(cfg_addr(9), 32'h0000_0601);
        check("R5 code6 out1 off", 32'(pad_oe[9]), 0);
        bus_wr(12'h008, 32'h200);
        check("R5 code6 out0 on", 32'(pad_oe[9]), 1);
        check("R5 code6 level", 32'(pad_level[9]), 0);
        bus_wr(cfg_addr(9), 32'h0000_0001);
        bus_wr(12'h004, 32'h200);
        check("R5 code0 on", 32'(pad_oe[9]), 1);
        bus_wr(cfg_addr(9), 32'h0000_0000);
        check("R5 dir input off", 32'(pad_oe[9]), 0);
        bus_wr(cfg_addr(9), 32'h2);
        bus_wr(12'h008, 32'h200);
    endtask

    task automatic t_pull_disconnected();
        logic [31:0] b;
        bus_wr(cfg_addr(3), 32'h0000_000E);
        settle(); in_bit(3, b); check("R6 pull-up", b, 1);
        bus_wr(cfg_addr(3), 32'h0000_0006);
        settle(); in_bit(3, b); check("R6 pull-down", b, 0);
        @(negedge clk); ext_drive_en[3] = 1'b1; ext_drive_level[3] = 1'b1;
        settle(); in_bit(3, b); check("R6 pull beats ext", b, 0);
        ext_drive_en[3] = 1'b0;
        bus_wr(cfg_addr(3), 32'h2);
    endtask

    task automatic t_floating();
        logic [31:0] b;
        bus_wr(cfg_addr(12), 32'h0000_000C);
        settle(); in_bit(12, b);
        check("R7 pull-up in", b, 1);
        check("R7 pull-up oe", 32'(pad_oe[12]), 1);
        check("R7 pull-up level", 32'(pad_level[12]), 1);
        bus_wr(cfg_addr(12), 32'h0000_0004);
        settle(); in_bit(12, b);
        check("R7 pull-down in", b, 0);
        check("R7 pull-down level", 32'(pad_level[12]), 0);
        bus_wr(cfg_addr(12), 32'h0000_0001);
        bus_wr(12'h004, 32'h1000);
        settle(); in_bit(12, b);
        check("R7 follows out", b, 1);
        bus_wr(cfg_addr(12), 32'h0000_0008);
        settle(); in_bit(12, b);
        check("R7 code2 no pad", 32'(pad_oe[12]), 0);
        check("R7 holds", b, 1);
        bus_wr(cfg_addr(12), 32'h2);
        bus_wr(12'h008, 32'h1000);
    endtask

    task automatic t_external();
        logic [31:0] b;
        bus_wr(cfg_addr(20), 32'h0);
        @(negedge clk); ext_drive_en[20] = 1'b1; ext_drive_level[20] = 1'b1;
        settle(); in_bit(20, b); check("R8 ext high", b, 1);
        @(negedge clk); ext_drive_level[20] = 1'b0;
        settle(); in_bit(20, b); check("R8 ext low", b, 0);
        check("R8 pad off", 32'(pad_oe[20]), 0);
        bus_wr(cfg_addr(20), 32'h0000_0004);
        @(negedge clk); ext_drive_level[20] = 1'b1;
        settle(); in_bit(20, b); check("R8 ext over pull", b, 1);
        check("R8 pull not driven", 32'(pad_oe[20]), 0);
        ext_drive_en[20] = 1'b0; ext_drive_level[20] = 1'b0;
        bus_wr(cfg_addr(20), 32'h2);
    endtask

    task automatic t_short();
        bus_wr(cfg_addr(25), 32'h0000_0001);
        bus_wr(12'h004, 32'h0200_0000);
        @(negedge clk); ext_drive_en[25] = 1'b1; ext_drive_level[25] = 1'b1;
        settle(); check("R9 same level no flag", 32'(short_flags[25]), 0);
        @(negedge clk); ext_drive_level[25] = 1'b0;
        settle(); check("R9 clash flag", 32'(short_flags[25]), 1);
        @(negedge clk); ext_drive_en[25] = 1'b0;
        settle(); check("R9 sticky", 32'(short_flags[25]), 1);
        bus_wr(cfg_addr(26), 32'h0000_0003);
        bus_wr(12'h004, 32'h0400_0000);
        @(negedge clk); ext_drive_en[26] = 1'b1; ext_drive_level[26] = 1'b0;
        settle(); check("R9 buffer off no flag", 32'(short_flags[26]), 0);
        @(negedge clk); ext_drive_en[26] = 1'b0;
    endtask

    task automatic t_bus_err();
        logic [31:0] v;
        check("R10 err clear before", 32'(bus_err), 0);
        bus_rd(12'h040, v);
        check("R10 unmapped read zero", v, 0);
        check("R10 err set", 32'(bus_err), 1);
        bus_wr(12'h00C, 32'hFFFF_FFFF);
        bus_wr(12'h002, 32'h0);
        bus_wr(12'h100, 32'h0);
        bus_rd(12'h000, v);
        check("R10 writes ignored", v, 32'h0600_0000);
        bus_rd(12'h100, v);
        check("R10 past cfg zero", v, 0);
        check("R10 err sticky", 32'(bus_err), 1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_out_regs();
        t_dir_regs();
        t_cfg_mirror();
        t_drive_modes();
        t_pull_disconnected();
        t_floating();
        t_external();
        t_short();
        t_bus_err();
        summary();
        $finish;
    end

endmodule